// File: doc/BRIEF.md
# Framebuffer Scanout Address Generator

This block produces the read requests that fetch a linear framebuffer from memory once per frame. Software programs the first-pixel address, the line length in bytes, the distance in bytes between line starts, and the index of the last line (lines minus one). It also programs a limit on requests in flight. All of these are captured on a frame-start pulse, so software may rewrite them at any time without disturbing the frame in progress.

After a frame start the generator walks the frame one line at a time. It cuts each line into bursts of up to 16 beats of 4 bytes. It presents each burst on a request/grant handshake as a byte address and a beat count. A separate completion pulse returns one unit of credit, so the number of granted but unfinished bursts never exceeds the captured limit. After the last burst of the last line is granted, the generator stays silent until the next frame start.

Top module: `fbscan_addr_gen`

## Requirements
- R1: While reset is asserted, and after reset until the first frame start, `req_o` is low and no bursts are outstanding.
- R2: Base, line length, pitch, last-line index and outstanding limit are sampled only in the cycle of `frame_start_i`. Changing them during a frame has no effect on that frame's requests.
- R3: When the line length is nonzero and credit is available, `req_o` rises in the cycle after the frame-start pulse, with `req_addr_o` equal to the captured base.
- R4: A line of L bytes takes ceil(L/4) beats. It is issued as bursts of 16 beats whose addresses advance by 64 bytes, and the final burst of the line carries the remaining 1 to 16 beats. `req_beats_o` is the binary beat count.
- R5: The first burst of each line after the first starts at the previous line's start address plus the pitch.
- R6: A frame issues bursts for exactly last-line-index + 1 lines. After the last burst is granted, `req_o` stays low until the next frame start.
- R7: Once raised, `req_o` stays high with unchanged address and beat count until `gnt_i` is seen, unless a frame start intervenes.
- R8: The outstanding count rises by one on each grant and falls by one on each `done_i`. `req_o` is never high while the count equals the limit. A limit field of 0, or any value above MAX_OUT, means MAX_OUT.
- R9: A frame start during a frame restarts the walk at the new base, drops any ungranted request, and keeps the outstanding count.
- R10: A line length of zero produces no requests for the whole frame.
- R11: A grant and a completion in the same cycle leave the outstanding count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | Single-cycle frame-start pulse |
| cfg_base_i | input | AW | Byte address of the first visible pixel |
| cfg_line_bytes_i | input | LEN_W | Bytes fetched per line |
| cfg_pitch_i | input | PITCH_W | Bytes between consecutive line starts |
| cfg_last_line_i | input | LINE_W | Number of lines minus one |
| cfg_max_out_i | input | OUT_W | Outstanding burst limit (0 = MAX_OUT) |
| req_o | output | 1 | Burst request valid |
| req_addr_o | output | AW | Burst start byte address |
| req_beats_o | output | BURST_W | Burst length in beats |
| gnt_i | input | 1 | Request accepted this cycle |
| done_i | input | 1 | One outstanding burst has completed |

## Verification
A wrong line base or burst cursor appears at the very next grant as an address that differs from the bench's computed list. A wrong remaining-beat count appears at the last burst of a line as a beat count other than the remainder, or as an extra or missing burst. A drifting outstanding counter appears within one cycle as `req_o` held while the bench's own count sits at the limit. It can also appear as a stall that never ends, and the watchdog catches that. Bursts issued past the last line show as grants with nothing left to expect, or as `req_o` high in the idle cycles after a frame.

// File: rtl/fbscan_pkg.sv
package fbscan_pkg;
  typedef enum logic {
    WALK_IDLE = 1'b0,
    WALK_RUN  = 1'b1
  } walk_state_e;

  function automatic int unsigned width_of(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/fbscan_cfg.sv
module fbscan_cfg #(
  parameter int unsigned AW         = 32,
  parameter int unsigned LEN_W      = 16,
  parameter int unsigned PITCH_W    = 16,
  parameter int unsigned LINE_W     = 12,
  parameter int unsigned MAX_OUT    = 8,
  parameter int unsigned OUT_W      = 4,
  parameter int unsigned BEAT_BYTES = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               frame_start_i,
  input  logic [LEN_W-1:0]   line_bytes_i,
  input  logic [PITCH_W-1:0] pitch_i,
  input  logic [LINE_W-1:0]  last_line_i,
  input  logic [OUT_W-1:0]   max_out_i,
  output logic [LEN_W-1:0]   start_beats_o,
  output logic [LEN_W-1:0]   beats_o,
  output logic [PITCH_W-1:0] pitch_o,
  output logic [LINE_W-1:0]  last_line_o,
  output logic [OUT_W-1:0]   cap_o
);
  localparam int unsigned SHIFT = $clog2(BEAT_BYTES);
  localparam logic [OUT_W-1:0] MAX_OUT_V = OUT_W'(MAX_OUT);

  logic [LEN_W:0]   rounded;
  logic [OUT_W-1:0] cap_in;

  generate
    if (BEAT_BYTES == 1) begin : g_byte_beats
      assign rounded = {1'b0, line_bytes_i};
    end else begin : g_wide_beats
      assign rounded = ({1'b0, line_bytes_i} + (LEN_W+1)'(BEAT_BYTES - 1)) >> SHIFT;
    end
  endgenerate

  assign start_beats_o = rounded[LEN_W-1:0];
  assign cap_in = (max_out_i == '0 || max_out_i > MAX_OUT_V) ? MAX_OUT_V : max_out_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beats_o     <= '0;
      pitch_o     <= '0;
      last_line_o <= '0;
      cap_o       <= MAX_OUT_V;
    end else if (frame_start_i) begin
      beats_o     <= start_beats_o;
      pitch_o     <= pitch_i;
      last_line_o <= last_line_i;
      cap_o       <= cap_in;
    end
  end

  // R2: captured settings move only on a frame start
  a_r2_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_i |=> ($stable(beats_o) && $stable(pitch_o) &&
                        $stable(last_line_o) && $stable(cap_o)));
endmodule

// File: rtl/fbscan_walker.sv
module fbscan_walker
  import fbscan_pkg::*;
#(
  parameter int unsigned AW         = 32,
  parameter int unsigned LEN_W      = 16,
  parameter int unsigned PITCH_W    = 16,
  parameter int unsigned LINE_W     = 12,
  parameter int unsigned MAX_BEATS  = 16,
  parameter int unsigned BEAT_BYTES = 4,
  parameter int unsigned BURST_W    = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               frame_start_i,
  input  logic [AW-1:0]      start_base_i,
  input  logic [LEN_W-1:0]   start_beats_i,
  input  logic [LEN_W-1:0]   beats_i,
  input  logic [PITCH_W-1:0] pitch_i,
  input  logic [LINE_W-1:0]  last_line_i,
  input  logic               fire_i,
  output logic               active_o,
  output logic [AW-1:0]      addr_o,
  output logic [BURST_W-1:0] burst_o
);
  localparam logic [AW-1:0]    STEP_A = AW'(MAX_BEATS * BEAT_BYTES);
  localparam logic [LEN_W-1:0] MAXB_L = LEN_W'(MAX_BEATS);

  walk_state_e       state_q;
  logic [AW-1:0]     line_base_q;
  logic [AW-1:0]     cur_q;
  logic [LEN_W-1:0]  left_q;
  logic [LINE_W-1:0] idx_q;
  logic              last_burst;
  logic              last_line;
  logic [AW-1:0]     next_line_base;

  assign last_burst     = (left_q <= MAXB_L);
  assign last_line      = (idx_q == last_line_i);
  assign next_line_base = line_base_q + AW'(pitch_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= WALK_IDLE;
      line_base_q <= '0;
      cur_q       <= '0;
      left_q      <= '0;
      idx_q       <= '0;
    end else if (frame_start_i) begin
      state_q     <= (start_beats_i != '0) ? WALK_RUN : WALK_IDLE;
      line_base_q <= start_base_i;
      cur_q       <= start_base_i;
      left_q      <= start_beats_i;
      idx_q       <= '0;
    end else if (fire_i && state_q == WALK_RUN) begin
      if (!last_burst) begin
        cur_q  <= cur_q + STEP_A;
        left_q <= left_q - MAXB_L;
      end else if (last_line) begin
        state_q <= WALK_IDLE;
      end else begin
        idx_q       <= idx_q + 1'b1;
        line_base_q <= next_line_base;
        cur_q       <= next_line_base;
        left_q      <= beats_i;
      end
    end
  end

  assign active_o = (state_q == WALK_RUN);
  assign addr_o   = cur_q;
  assign burst_o  = last_burst ? left_q[BURST_W-1:0] : BURST_W'(MAX_BEATS);

  // R4: every presented burst is 1..MAX_BEATS beats
  a_r4_burst_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |-> (burst_o != '0 && burst_o <= BURST_W'(MAX_BEATS)));

  // R6: an idle walker stays idle until a frame start
  a_r6_idle_stays: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == WALK_IDLE && !frame_start_i) |=> state_q == WALK_IDLE);

  // R5: the line after a granted line-end burst starts one pitch further on
  a_r5_next_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && active_o && last_burst && !last_line && !frame_start_i)
      |=> cur_q == $past(line_base_q) + AW'(pitch_i));
endmodule

// File: rtl/fbscan_credit.sv
module fbscan_credit #(
  parameter int unsigned OUT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  input  logic             done_i,
  input  logic [OUT_W-1:0] cap_i,
  output logic             avail_o
);
  logic [OUT_W-1:0] cnt_q;
  logic             dec;

  assign dec = done_i && (cnt_q != '0 || fire_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (fire_i && !dec)  cnt_q <= cnt_q + 1'b1;
    else if (!fire_i && dec)  cnt_q <= cnt_q - 1'b1;
  end

  assign avail_o = (cnt_q < cap_i);

  // R8: a grant without completion adds exactly one
  a_r8_grant_counts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && !done_i) |=> cnt_q == $past(cnt_q) + 1'b1);

  // R11: grant and completion together cancel
  a_r11_both_cancel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && done_i) |=> $stable(cnt_q));

  // R8: completions never wrap the counter below zero
  a_r8_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && !fire_i) |=> cnt_q == '0);
endmodule

// File: rtl/fbscan_addr_gen.sv
module fbscan_addr_gen #(
  parameter int unsigned AW         = 32,
  parameter int unsigned LEN_W      = 16,
  parameter int unsigned PITCH_W    = 16,
  parameter int unsigned LINE_W     = 12,
  parameter int unsigned MAX_BEATS  = 16,
  parameter int unsigned BEAT_BYTES = 4,
  parameter int unsigned MAX_OUT    = 8,
  parameter int unsigned OUT_W      = fbscan_pkg::width_of(MAX_OUT),
  parameter int unsigned BURST_W    = fbscan_pkg::width_of(MAX_BEATS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               frame_start_i,
  input  logic [AW-1:0]      cfg_base_i,
  input  logic [LEN_W-1:0]   cfg_line_bytes_i,
  input  logic [PITCH_W-1:0] cfg_pitch_i,
  input  logic [LINE_W-1:0]  cfg_last_line_i,
  input  logic [OUT_W-1:0]   cfg_max_out_i,
  output logic               req_o,
  output logic [AW-1:0]      req_addr_o,
  output logic [BURST_W-1:0] req_beats_o,
  input  logic               gnt_i,
  input  logic               done_i
);
  logic [LEN_W-1:0]   start_beats;
  logic [LEN_W-1:0]   beats_q;
  logic [PITCH_W-1:0] pitch_q;
  logic [LINE_W-1:0]  last_line_q;
  logic [OUT_W-1:0]   cap_q;
  logic               active;
  logic               avail;
  logic               fire;

  assign fire  = req_o && gnt_i;
  assign req_o = active && avail;

  fbscan_cfg #(
    .AW(AW), .LEN_W(LEN_W), .PITCH_W(PITCH_W), .LINE_W(LINE_W),
    .MAX_OUT(MAX_OUT), .OUT_W(OUT_W), .BEAT_BYTES(BEAT_BYTES)
  ) cfg_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .frame_start_i (frame_start_i),
    .line_bytes_i  (cfg_line_bytes_i),
    .pitch_i       (cfg_pitch_i),
    .last_line_i   (cfg_last_line_i),
    .max_out_i     (cfg_max_out_i),
    .start_beats_o (start_beats),
    .beats_o       (beats_q),
    .pitch_o       (pitch_q),
    .last_line_o   (last_line_q),
    .cap_o         (cap_q)
  );

  fbscan_walker #(
    .AW(AW), .LEN_W(LEN_W), .PITCH_W(PITCH_W), .LINE_W(LINE_W),
    .MAX_BEATS(MAX_BEATS), .BEAT_BYTES(BEAT_BYTES), .BURST_W(BURST_W)
  ) walker_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .frame_start_i (frame_start_i),
    .start_base_i  (cfg_base_i),
    .start_beats_i (start_beats),
    .beats_i       (beats_q),
    .pitch_i       (pitch_q),
    .last_line_i   (last_line_q),
    .fire_i        (fire),
    .active_o      (active),
    .addr_o        (req_addr_o),
    .burst_o       (req_beats_o)
  );

  fbscan_credit #(
    .OUT_W(OUT_W)
  ) credit_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fire_i  (fire),
    .done_i  (done_i),
    .cap_i   (cap_q),
    .avail_o (avail)
  );

  // R7: a waiting request holds its content
  a_r7_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !gnt_i && !frame_start_i)
      |=> (req_o && $stable(req_addr_o) && $stable(req_beats_o)));

  // R3: a frame start with data always arms the walker at the new base
  a_r3_start_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_start_i && cfg_line_bytes_i != '0)
      |=> (active && req_addr_o == $past(cfg_base_i)));

  // R10: an empty line length never raises a request
  a_r10_empty_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_start_i && cfg_line_bytes_i == '0) |=> !req_o);
endmodule

// File: tb/fbscan_addr_gen_tb_top.sv
module fbscan_addr_gen_tb_top;
  localparam int MAXQ = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fs = 1'b0;
  logic [31:0] base = '0;
  logic [15:0] len = '0;
  logic [15:0] pitch = '0;
  logic [11:0] lines = '0;
  logic [3:0]  cap = '0;
  logic        req;
  logic [31:0] addr;
  logic [4:0]  beats;
  logic        gnt = 1'b0;
  logic        done = 1'b0;

  always #2 clk = ~clk;

  fbscan_addr_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .frame_start_i(fs),
    .cfg_base_i(base), .cfg_line_bytes_i(len), .cfg_pitch_i(pitch),
    .cfg_last_line_i(lines), .cfg_max_out_i(cap),
    .req_o(req), .req_addr_o(addr), .req_beats_o(beats),
    .gnt_i(gnt), .done_i(done)
  );

  int checks = 0;
  int fails = 0;
  logic [31:0] exp_addr [MAXQ];
  int          exp_beats [MAXQ];
  int exp_n = 0, exp_rd = 0;
  int out_n = 0, cap_eff = 8;
  bit prev_req = 0, prev_g = 0, prev_both = 0;
  logic [31:0] prev_addr = '0;
  int cyc = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int cap_of(input int c);
    return (c == 0 || c > 8) ? 8 : c;
  endfunction

  function automatic void build(input logic [31:0] b, input int l, input int p, input int n);
    int bt = (l + 3) / 4;
    exp_n = 0; exp_rd = 0;
    if (bt == 0) return;
    for (int ln = 0; ln <= n; ln++) begin
      logic [31:0] a = b + 32'(ln * p);
      int left = bt;
      while (left > 0) begin
        int k = (left > 16) ? 16 : left;
        exp_addr[exp_n] = a;
        exp_beats[exp_n] = k;
        exp_n++;
        a += 32'd64;
        left -= k;
      end
    end
  endfunction

  // one cycle: entered and left at a falling edge
  task automatic step(input bit allow_g, input int gp, input int dp);
    bit g, d;
    if (prev_req && !prev_g)
      chk(req && addr == prev_addr, "R7", {31'd0, req}, 1);
    if (req)
      chk(out_n < cap_eff, prev_both ? "R11" : "R8", out_n, cap_eff);
    g = allow_g && req && (($urandom % 100) < gp);
    d = (out_n > 0) && (($urandom % 100) < dp);
    if (g) begin
      chk(exp_rd < exp_n, "R6", exp_rd, exp_n);
      if (exp_rd < exp_n) begin
        chk(addr == exp_addr[exp_rd], "R5", addr, exp_addr[exp_rd]);
        chk(int'(beats) == exp_beats[exp_rd], "R4", beats, exp_beats[exp_rd]);
        exp_rd++;
      end
    end
    out_n += int'(g) - int'(d);
    prev_both = g && d;
    prev_req = req; prev_g = g; prev_addr = addr;
    gnt = g; done = d;
    @(negedge clk);
  endtask

  task automatic start_frame(input logic [31:0] b, input int l, input int p, input int n,
                             input int c, input string tag);
    base = b; len = 16'(l); pitch = 16'(p); lines = 12'(n); cap = 4'(c);
    fs = 1'b1; gnt = 1'b0; done = 1'b0;
    build(b, l, p, n);
    @(negedge clk);
    fs = 1'b0;
    cap_eff = cap_of(c);
    prev_req = 0; prev_g = 0; prev_both = 0;
    if (l > 0 && out_n < cap_eff)
      chk(req && addr == b, tag, addr, b);
  endtask

  task automatic finish_frame(input int gp, input int dp, input bit scramble);
    int guard = 0;
    if (scramble) begin
      base = $urandom; len = 16'($urandom); pitch = 16'($urandom);
      lines = 12'($urandom); cap = 4'($urandom);
    end
    while ((exp_rd < exp_n || out_n > 0) && guard < 20000) begin
      step(1, gp, dp);
      guard++;
    end
    chk(exp_rd == exp_n, scramble ? "R2" : "R6", exp_rd, exp_n);
    for (int i = 0; i < 4; i++) begin
      chk(!req, "R6", req, 0);
      step(1, 100, 50);
    end
    gnt = 0; done = 0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk); @(negedge clk);
    chk(!req, "R1", req, 0);
    rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(!req, "R1", req, 0);

    // directed: remainder bursts, 2 lines, pitch larger than length
    start_frame(32'h1000_0000, 200, 256, 1, 0, "R3");
    finish_frame(100, 100, 0);
    // exact multiple of 64 bytes, tight limit of one
    start_frame(32'h2000_0040, 128, 128, 2, 1, "R3");
    finish_frame(70, 60, 0);
    // partial final word rounds up to a beat
    start_frame(32'h0000_0100, 6, 32, 3, 3, "R3");
    finish_frame(80, 30, 0);
    // empty line length
    start_frame(32'h3000_0000, 0, 64, 3, 2, "R10");
    for (int i = 0; i < 20; i++) begin
      chk(!req, "R10", req, 0);
      step(1, 100, 0);
    end
    // settings changed mid-frame are ignored
    start_frame(32'h4000_0000, 300, 512, 4, 4, "R3");
    finish_frame(60, 40, 1);
    // restart mid-frame keeps outstanding bursts
    start_frame(32'h5000_0000, 256, 1024, 5, 6, "R3");
    while (exp_rd < 5) step(1, 100, 10);
    start_frame(32'h6000_0200, 100, 160, 2, 6, "R9");
    finish_frame(70, 40, 0);
    // limit above MAX_OUT clamps
    start_frame(32'h7000_0000, 64, 64, 7, 12, "R8");
    finish_frame(100, 5, 0);

    // random frames, including limit one with simultaneous grant/done
    for (int f = 0; f < 25; f++) begin
      int l = int'($urandom % 320);
      int p = l + int'($urandom % 128);
      int n = int'($urandom % 8);
      int c = (f % 3 == 0) ? 1 : int'($urandom % 10);
      start_frame($urandom & 32'hFFFF_FFFC, l, p, n, c, l == 0 ? "R10" : "R3");
      finish_frame(30 + int'($urandom % 70), 20 + int'($urandom % 80), f[0]);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule